// File: doc/BRIEF.md
# Single DMA Transfer Channel

This block is one direct-memory-access channel. Software programs it through a small register window: a control word, a remaining-unit count, a peripheral-side address and a memory-side address. Once it is enabled, the channel moves data one unit at a time. Each unit is a read on its bus master port followed by a write, with the data held in the channel between the two. The read comes from one address side and the write goes to the other, as the direction bit selects.

Each side has its own increment switch and its own unit size (byte, halfword or word). A side that increments advances by its own unit size after every unit. Units are paced by a level request from a peripheral, or run back to back when the memory-to-memory bit is set. In normal mode the channel stops when the count reaches zero. In circular mode the count and both addresses reload from the values they held at the moment the channel was enabled. Sticky flags record complete, half-way and bus-error events, and each can raise an interrupt.

The channel leaves arbitration to an outside arbiter and exports its programmed priority for it. The bus master port uses a request/grant handshake. The request stays up, with the address, direction of access, size and write data all steady, until a one-cycle grant. Read data and the error indication are valid in the grant cycle.

Top module: `dmac_channel`

## Requirements
- R1: After synchronous reset, every register reads 0: the control word, count, both addresses and status. `irq`, `bus_req` and `per_ack` are low.
- R2: Register window at `reg_addr`. 0 is control: bit0 enable, bit1 complete irq enable, bit2 half irq enable, bit3 error irq enable, bit4 direction (1 = memory to peripheral), bit5 circular, bit6 peripheral increment, bit7 memory increment, bits9:8 peripheral size, bits11:10 memory size, bits13:12 priority, bit14 memory-to-memory. 1 is count, 2 is peripheral address, 3 is memory address and 4 is status. Reads appear on `reg_rdata` one clock later, and the count and addresses can be read at any time.
- R3: Writes to count and to either address register are ignored while the enable bit is set.
- R4: With memory-to-memory clear, no bus access starts while `per_req` is low. `per_ack` pulses for one cycle after each completed unit.
- R5: With memory-to-memory set, units run back to back without `per_req`.
- R6: Direction 0 reads from the peripheral address and writes to the memory address. Direction 1 does the reverse.
- R7: Size codes are 00 byte, 01 halfword and 10 word (11 acts as word). An address with its increment bit set advances by its own side's unit size after each unit. An address with the bit clear stays fixed.
- R8: Bus data is right-justified. Read data is cut to the source size and zero-extended or truncated to the destination size.
- R9: Each unit decrements the count by one. When the count reaches 0 the complete flag is set, and in normal mode no further access starts.
- R10: The half flag is set by the unit that leaves the count at floor(N/2), where N is the count held at enable.
- R11: In circular mode, the unit that reaches 0 reloads the count and both addresses with their values at enable, and transfers continue.
- R12: An error on the bus sets the error flag and clears the enable bit. The count and addresses keep their values from before the failed unit, and the destination is not written.
- R13: Status bits are: bit0 global (OR of the others), bit1 complete, bit2 half and bit3 error. Writing 1 to status bit n clears flag n, and bit0 clears all flags. `irq` is high one cycle after any flag whose enable is set.
- R14: While `bus_req` is high and no grant has arrived, the request, address and write/read select are held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| per_req | input | 1 | Peripheral transfer request (level) |
| per_ack | output | 1 | One-cycle pulse after each completed unit |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | AW | Byte address of the access |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | 32 | Right-justified write data |
| bus_gnt | input | 1 | One-cycle grant completing the access |
| bus_rdata | input | 32 | Right-justified read data, valid with grant |
| bus_err | input | 1 | Access error, valid with grant |
| chan_prio | output | 2 | Programmed priority for an outside arbiter |
| irq | output | 1 | Channel interrupt |

## Verification
A count that steps wrong shows up in the count register at the next read. It also shows as a missing or extra access once the run should have ended, and as complete or half flags that rise on the wrong unit. A bad address pointer or a wrong size choice corrupts the destination bytes of that very unit, so the bench compares the target memory byte by byte, including neighbours that must stay untouched. A lost shadow copy only shows at the circular wrap, so the bench reads the count and the address just after the wrap. Error handling is observed through the enable bit and through the count and source address frozen at the failed unit.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int DW = 32;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_CNT  = 3'd1;
  localparam logic [2:0] OFS_PADR = 3'd2;
  localparam logic [2:0] OFS_MADR = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;

  // Control word, bit 0 (en) is the LSB.
  typedef struct packed {
    logic       m2m;
    logic [1:0] prio;
    logic [1:0] msize;
    logic [1:0] psize;
    logic       minc;
    logic       pinc;
    logic       circ;
    logic       dir;
    logic       teie;
    logic       htie;
    logic       tcie;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_t;

  function automatic logic [2:0] nbytes(input logic [1:0] sz);
    case (sz)
      2'd0:    nbytes = 3'd1;
      2'd1:    nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
  endfunction

  function automatic logic [DW-1:0] fit(input logic [DW-1:0] d, input logic [1:0] sz);
    case (sz)
      2'd0:    fit = {{(DW-8){1'b0}}, d[7:0]};
      2'd1:    fit = {{(DW-16){1'b0}}, d[15:0]};
      default: fit = d;
    endcase
  endfunction
endpackage

// File: rtl/dmac_ptr.sv
module dmac_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_data,
  input  logic          cap,
  input  logic          adv,
  input  logic          inc,
  input  logic [1:0]    size,
  input  logic          wrap,
  output logic [AW-1:0] cur
);
  import dmac_pkg::*;

  logic [AW-1:0] shadow;
  logic [AW-1:0] step;

  always_comb step = AW'(nbytes(size));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= '0;
      shadow <= '0;
    end else begin
      if (sw_we)          cur <= sw_data;
      else if (wrap)      cur <= shadow;
      else if (adv && inc) cur <= cur + step;
      if (cap) shadow <= cur;
    end
  end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          unit_done,
  input  logic          bus_fault,
  input  logic [AW-1:0] p_cur,
  input  logic [AW-1:0] m_cur,
  output ctrl_t         ctrl,
  output logic          en_rise,
  output logic          wrap,
  output logic          adr_we_p,
  output logic          adr_we_m,
  output logic          cnt_nz,
  output logic [CW-1:0] cnt,
  output logic [2:0]    flags,
  output logic          irq
);
  logic          ctrl_wr;
  logic [CW-1:0] cnt_dec;
  logic [CW-1:0] cnt_shadow;
  logic          last_hit;
  logic          half_hit;
  logic [3:0]    clr;
  logic          clr_tc, clr_ht, clr_te;

  always_comb begin
    ctrl_wr  = reg_we && (reg_addr == OFS_CTRL);
    en_rise  = ctrl_wr && reg_wdata[0] && !ctrl.en;
    adr_we_p = reg_we && (reg_addr == OFS_PADR) && !ctrl.en;
    adr_we_m = reg_we && (reg_addr == OFS_MADR) && !ctrl.en;
    cnt_dec  = cnt - 1'b1;
    cnt_nz   = (cnt != '0);
    last_hit = unit_done && (cnt_dec == '0);
    half_hit = unit_done && (cnt_dec == (cnt_shadow >> 1));
    wrap     = last_hit && ctrl.circ;
    clr      = (reg_we && (reg_addr == OFS_STAT)) ? reg_wdata[3:0] : 4'd0;
    clr_tc   = clr[0] | clr[1];
    clr_ht   = clr[0] | clr[2];
    clr_te   = clr[0] | clr[3];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl       <= '0;
      cnt        <= '0;
      cnt_shadow <= '0;
      flags      <= '0;
      irq        <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      if (ctrl_wr)   ctrl    <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (bus_fault) ctrl.en <= 1'b0;

      if (unit_done)
        cnt <= wrap ? cnt_shadow : cnt_dec;
      else if (reg_we && (reg_addr == OFS_CNT) && !ctrl.en)
        cnt <= reg_wdata[CW-1:0];
      if (en_rise) cnt_shadow <= cnt;

      flags[0] <= (flags[0] & ~clr_tc) | last_hit;
      flags[1] <= (flags[1] & ~clr_ht) | half_hit;
      flags[2] <= (flags[2] & ~clr_te) | bus_fault;

      irq <= (flags[0] & ctrl.tcie) | (flags[1] & ctrl.htie) | (flags[2] & ctrl.teie);

      case (reg_addr)
        OFS_CTRL: reg_rdata <= 32'(ctrl);
        OFS_CNT:  reg_rdata <= 32'(cnt);
        OFS_PADR: reg_rdata <= 32'(p_cur);
        OFS_MADR: reg_rdata <= 32'(m_cur);
        OFS_STAT: reg_rdata <= {28'd0, flags[2], flags[1], flags[0], |flags};
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
  import dmac_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          m2m,
  input  logic          dir,
  input  logic [1:0]    psize,
  input  logic [1:0]    msize,
  input  logic          cnt_nz,
  input  logic          per_req,
  input  logic [AW-1:0] p_cur,
  input  logic [AW-1:0] m_cur,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_err,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  output logic          unit_done,
  output logic          fault,
  output logic          per_ack
);
  st_t           st;
  logic [DW-1:0] data_q;
  logic [1:0]    src_sz, dst_sz;
  logic [AW-1:0] rd_a, wr_a;
  logic          start;

  always_comb begin
    src_sz    = dir ? msize : psize;
    dst_sz    = dir ? psize : msize;
    rd_a      = dir ? m_cur : p_cur;
    wr_a      = dir ? p_cur : m_cur;
    start     = en && cnt_nz && (m2m || per_req);
    bus_req   = (st != ST_IDLE);
    bus_we    = (st == ST_WR);
    bus_addr  = bus_we ? wr_a : rd_a;
    bus_size  = bus_we ? dst_sz : src_sz;
    bus_wdata = fit(data_q, dst_sz);
    unit_done = (st == ST_WR) && bus_gnt && !bus_err;
    fault     = bus_req && bus_gnt && bus_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      data_q  <= '0;
      per_ack <= 1'b0;
    end else begin
      per_ack <= unit_done;
      case (st)
        ST_IDLE: if (start) st <= ST_RD;
        ST_RD: if (bus_gnt) begin
          if (bus_err) st <= ST_IDLE;
          else begin
            data_q <= fit(bus_rdata, src_sz);
            st     <= ST_WR;
          end
        end
        ST_WR: if (bus_gnt) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          per_req,
  output logic          per_ack,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [31:0]   bus_wdata,
  input  logic          bus_gnt,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_err,
  output logic [1:0]    chan_prio,
  output logic          irq
);
  localparam int NSIDE = 2; // 0 = peripheral side, 1 = memory side

  ctrl_t         ctrl;
  logic          ctrl_en;
  logic          en_rise, wrap, adr_we_p, adr_we_m, cnt_nz;
  logic          unit_done, bus_fault;
  logic [CW-1:0] cnt;
  logic [2:0]    flags;
  logic [AW-1:0] side_cur [NSIDE];
  logic          side_we  [NSIDE];
  logic          side_inc [NSIDE];
  logic [1:0]    side_sz  [NSIDE];

  always_comb begin
    ctrl_en     = ctrl.en;
    chan_prio   = ctrl.prio;
    side_we[0]  = adr_we_p;
    side_we[1]  = adr_we_m;
    side_inc[0] = ctrl.pinc;
    side_inc[1] = ctrl.minc;
    side_sz[0]  = ctrl.psize;
    side_sz[1]  = ctrl.msize;
  end

  dmac_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .unit_done(unit_done), .bus_fault(bus_fault),
    .p_cur(side_cur[0]), .m_cur(side_cur[1]),
    .ctrl(ctrl), .en_rise(en_rise), .wrap(wrap),
    .adr_we_p(adr_we_p), .adr_we_m(adr_we_m),
    .cnt_nz(cnt_nz), .cnt(cnt), .flags(flags), .irq(irq)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dmac_ptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst(rst),
      .sw_we(side_we[s]), .sw_data(reg_wdata[AW-1:0]),
      .cap(en_rise), .adv(unit_done), .inc(side_inc[s]),
      .size(side_sz[s]), .wrap(wrap), .cur(side_cur[s])
    );
  end

  dmac_engine #(.AW(AW)) u_eng (
    .clk(clk), .rst(rst),
    .en(ctrl_en), .m2m(ctrl.m2m), .dir(ctrl.dir),
    .psize(ctrl.psize), .msize(ctrl.msize),
    .cnt_nz(cnt_nz), .per_req(per_req),
    .p_cur(side_cur[0]), .m_cur(side_cur[1]),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .unit_done(unit_done), .fault(bus_fault), .per_ack(per_ack)
  );
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_gnt,
  input logic          bus_err,
  input logic [AW-1:0] bus_addr,
  input logic          per_ack,
  input logic          ctrl_en,
  input logic [CW-1:0] cnt_cur,
  input logic [2:0]    flags,
  input logic          irq
);
  p_req_hold_r14: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  p_err_disable_r12: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_gnt && bus_err |=> !ctrl_en);

  p_ack_after_write_r4: assert property (@(posedge clk) disable iff (rst)
    per_ack |-> $past(bus_req && bus_we && bus_gnt && !bus_err));

  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    per_ack && ($past(cnt_cur) != CW'(1)) |-> cnt_cur == CW'($past(cnt_cur) - 1'b1));

  p_last_sets_done_r9: assert property (@(posedge clk) disable iff (rst)
    per_ack && ($past(cnt_cur) == CW'(1)) |-> flags[0]);

  p_start_needs_count_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(cnt_cur) != '0);

  p_irq_from_flag_r13: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flags) != 3'd0);
endmodule

bind dmac_channel dmac_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_gnt(bus_gnt),
  .bus_err(bus_err), .bus_addr(bus_addr), .per_ack(per_ack), .ctrl_en(ctrl_en),
  .cnt_cur(cnt), .flags(flags), .irq(irq)
);

// File: tb/tb_dmac_channel.sv
`timescale 1ns/1ps
module tb_dmac_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        per_req = 1'b0;
  logic        per_ack;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic        bus_gnt = 1'b0;
  logic [31:0] bus_rdata = 32'd0;
  logic        bus_err = 1'b0;
  logic [1:0]  chan_prio;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  int n_acc = 0;
  logic [7:0] tmem [0:255];
  logic       err_arm = 1'b0;
  logic [7:0] err_adr = 8'd0;
  int         wait_n = 0;

  always #4 clk = ~clk;

  dmac_channel dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .per_req(per_req), .per_ack(per_ack), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .chan_prio(chan_prio), .irq(irq)
  );

  // bus slave model: grants after wait_n idle cycles, data right-justified, little-endian
  initial begin
    int wc;
    wc = 0;
    forever begin
      @(negedge clk);
      if (bus_gnt) begin
        bus_gnt = 1'b0;
        bus_err = 1'b0;
      end else if (bus_req) begin
        if (wc < wait_n) wc++;
        else begin
          int nb;
          logic [7:0] a;
          wc = 0;
          bus_gnt = 1'b1;
          n_acc++;
          nb = (bus_size == 2'd0) ? 1 : (bus_size == 2'd1) ? 2 : 4;
          a = bus_addr[7:0];
          if (err_arm && !bus_we && a == err_adr) begin
            bus_err = 1'b1;
            err_arm = 1'b0;
          end else if (bus_we) begin
            for (int i = 0; i < nb; i++) tmem[8'(a + i)] = bus_wdata[8*i +: 8];
          end else begin
            bus_rdata = 32'd0;
            for (int i = 0; i < nb; i++) bus_rdata[8*i +: 8] = tmem[8'(a + i)];
          end
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: act=hung exp=finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic setup(input logic [31:0] pa, input logic [31:0] ma, input logic [31:0] n);
    reg_wr(3'd0, 32'd0);
    reg_wr(3'd4, 32'h1);
    reg_wr(3'd2, pa);
    reg_wr(3'd3, ma);
    reg_wr(3'd1, n);
  endtask

  task automatic one_unit();
    per_req = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (per_ack) break;
    end
    per_req = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 300; i++) begin
      reg_rd(3'd4, s);
      if (s[1]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      reg_rd(3'(a), v);
      chk("R1 register reset", v, 32'd0);
    end
    chk("R1 irq reset", 32'(irq), 32'd0);
    chk("R1 bus_req reset", 32'(bus_req), 32'd0);
    chk("R1 per_ack reset", 32'(per_ack), 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    int acc0;
    setup(32'h10, 32'h40, 32'd5);
    reg_wr(3'd0, 32'h3001);  // enable, priority 3
    reg_rd(3'd0, v); chk("R2 ctrl readback", v, 32'h3001);
    chk("R2 priority output", 32'(chan_prio), 32'd3);
    reg_rd(3'd2, v); chk("R2 periph addr readback", v, 32'h10);
    reg_wr(3'd1, 32'd9);
    reg_wr(3'd2, 32'h77);
    reg_wr(3'd3, 32'h78);
    reg_rd(3'd1, v); chk("R3 count write ignored", v, 32'd5);
    reg_rd(3'd2, v); chk("R3 periph addr write ignored", v, 32'h10);
    reg_rd(3'd3, v); chk("R3 mem addr write ignored", v, 32'h40);
    acc0 = n_acc;
    repeat (20) @(negedge clk);
    chk("R4 no access without request", 32'(n_acc - acc0), 32'd0);
    reg_wr(3'd0, 32'd0);
  endtask

  task automatic t_paced();
    logic [31:0] v;
    int acc0;
    for (int i = 0; i < 4; i++) tmem[8'h20 + i] = 8'h00;
    tmem[8'h24] = 8'hAA;
    setup(32'h80, 32'h20, 32'd4);
    wait_n = 2;
    reg_wr(3'd0, 32'h81);  // enable, memory increment, periph->memory
    for (int k = 0; k < 4; k++) begin
      tmem[8'h80] = 8'(8'h30 + k);
      one_unit();
      if (k == 1) begin
        reg_rd(3'd4, v); chk("R10 half flag after 2 of 4", v, 32'h5);
        reg_rd(3'd1, v); chk("R2 count readable mid-run", v, 32'd2);
      end
    end
    wait_n = 0;
    for (int i = 0; i < 4; i++) chk("R6 R7 paced dest byte", 32'(tmem[8'h20 + i]), 32'(8'h30 + i));
    chk("R7 no write past end", 32'(tmem[8'h24]), 32'hAA);
    reg_rd(3'd2, v); chk("R7 fixed periph addr", v, 32'h80);
    reg_rd(3'd3, v); chk("R7 byte memory step", v, 32'h24);
    reg_rd(3'd4, v); chk("R9 complete flag", v, 32'h7);
    chk("R13 irq stays low without enables", 32'(irq), 32'd0);
    acc0 = n_acc;
    per_req = 1'b1;
    repeat (15) @(negedge clk);
    per_req = 1'b0;
    chk("R9 normal mode stops", 32'(n_acc - acc0), 32'd0);
    reg_wr(3'd4, 32'h1);
    reg_rd(3'd4, v); chk("R13 clear all flags", v, 32'd0);
  endtask

  task automatic t_m2m();
    logic [31:0] v;
    for (int i = 0; i < 12; i++) tmem[i] = 8'(i + 1);
    setup(32'h00, 32'hA0, 32'd3);
    reg_wr(3'd0, 32'h4AC1);  // word both sides, both increment, free-running
    wait_done();
    for (int i = 0; i < 12; i++) chk("R5 word copy byte", 32'(tmem[8'hA0 + i]), 32'(i + 1));
    reg_rd(3'd2, v); chk("R7 word periph step", v, 32'h0C);
    reg_rd(3'd3, v); chk("R7 word memory step", v, 32'hAC);
    reg_rd(3'd1, v); chk("R9 count at zero", v, 32'd0);
  endtask

  task automatic t_dir_size();
    for (int i = 0; i < 8; i++) tmem[8'h90 + i] = 8'hFF;
    tmem[8'h60] = 8'h34; tmem[8'h61] = 8'h12; tmem[8'h62] = 8'h78; tmem[8'h63] = 8'h56;
    setup(32'h90, 32'h60, 32'd2);
    reg_wr(3'd0, 32'h46D1);  // mem->periph, mem halfword, periph word, both inc
    wait_done();
    chk("R6 R8 zero-extend word0", {tmem[8'h93], tmem[8'h92], tmem[8'h91], tmem[8'h90]}, 32'h00001234);
    chk("R6 R8 zero-extend word1", {tmem[8'h97], tmem[8'h96], tmem[8'h95], tmem[8'h94]}, 32'h00005678);
    tmem[8'h68] = 8'hEF; tmem[8'h69] = 8'hBE; tmem[8'h6A] = 8'hAD; tmem[8'h6B] = 8'hDE;
    tmem[8'h9C] = 8'h11; tmem[8'h9D] = 8'h11;
    setup(32'h9C, 32'h68, 32'd1);
    reg_wr(3'd0, 32'h4811);  // mem word -> periph byte
    wait_done();
    chk("R8 truncate to byte", 32'(tmem[8'h9C]), 32'hEF);
    chk("R8 neighbour untouched", 32'(tmem[8'h9D]), 32'h11);
  endtask

  task automatic t_circ();
    logic [31:0] v;
    tmem[8'hC0] = 8'h00; tmem[8'hC1] = 8'h00;
    setup(32'h80, 32'hC0, 32'd2);
    reg_wr(3'd0, 32'hA1);  // circular, memory increment, paced
    for (int k = 0; k < 2; k++) begin tmem[8'h80] = 8'(8'h50 + k); one_unit(); end
    reg_rd(3'd1, v); chk("R11 count reload", v, 32'd2);
    reg_rd(3'd3, v); chk("R11 address reload", v, 32'hC0);
    reg_rd(3'd4, v); chk("R11 complete at wrap", 32'(v[1]), 32'd1);
    tmem[8'h80] = 8'h52; one_unit();
    reg_rd(3'd1, v); chk("R11 count after wrap", v, 32'd1);
    reg_rd(3'd3, v); chk("R11 address after wrap", v, 32'hC1);
    chk("R11 second pass data", 32'(tmem[8'hC0]), 32'h52);
    chk("R11 first pass data", 32'(tmem[8'hC1]), 32'h51);
  endtask

  task automatic t_err();
    logic [31:0] v;
    tmem[0] = 8'h0A; tmem[1] = 8'h0B; tmem[2] = 8'h0C;
    tmem[8'hD0] = 8'hEE; tmem[8'hD1] = 8'hEE;
    setup(32'h00, 32'hD0, 32'd3);
    err_adr = 8'h01; err_arm = 1'b1;
    reg_wr(3'd0, 32'h40C9);  // error irq enable, both inc, free-running
    for (int i = 0; i < 100; i++) begin
      reg_rd(3'd0, v);
      if (!v[0]) break;
    end
    chk("R12 enable cleared", 32'(v[0]), 32'd0);
    reg_rd(3'd4, v); chk("R12 R13 error and global flags", v, 32'h9);
    reg_rd(3'd1, v); chk("R12 count frozen", v, 32'd2);
    reg_rd(3'd2, v); chk("R12 source addr frozen", v, 32'h01);
    chk("R12 first unit written", 32'(tmem[8'hD0]), 32'h0A);
    chk("R12 failed unit not written", 32'(tmem[8'hD1]), 32'hEE);
    chk("R13 irq on error", 32'(irq), 32'd1);
    reg_wr(3'd4, 32'h8);
    @(negedge clk);
    chk("R13 irq drops after clear", 32'(irq), 32'd0);
    reg_rd(3'd4, v); chk("R13 error flag cleared", v, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) tmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_paced();
    t_m2m();
    t_dir_size();
    t_circ();
    t_err();
    summary();
    $finish;
  end
endmodule